// File: doc/BRIEF.md
# Block-Floating-Point Barrel Shifter

This unit is the shift stage of a 16-bit fixed-point datapath. Each cycle it takes one 16-bit operand and one opcode. It places the operand in the upper or lower half of a 32-bit field and shifts that field left or right by a signed amount, with either zero fill or sign fill. The 32-bit answer is registered, so any unit that consumes it sees it on the next cycle.

For block-floating-point work the unit also keeps an exponent register. An exponent-detect operation counts the operand's redundant sign bits and stores the result as a negative exponent. A normalize operation then shifts left by that amount, so the first bit that differs from the sign lands next to the sign bit. A denormalize operation shifts by a stored exponent, which can also be loaded directly from the amount input. A merge flag ORs a new shifted value into the current result, so software can build a 32-bit word from two 16-bit halves.

Top module: `bfs_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0 and `exponent` becomes 0.
- R2: With `hi_sel`=1 the operand is placed in bits 31:16 of a 32-bit field and bits 15:0 are zero. With `hi_sel`=0 the operand is placed in bits 15:0. The upper bits are then copies of operand bit 15 when the field is arithmetic, and zero otherwise.
- R3: Opcode 1 (logical shift) writes the placed field shifted by `amount` to `result` at the next edge. `amount` is read as 8-bit two's complement: positive values shift left and negative values shift right, with zero fill in both directions.
- R4: Opcode 2 (arithmetic shift) uses an arithmetic field. A right shift fills from bit 31 of the placed field.
- R5: A shift magnitude of 32 or more to the left gives 0. The same magnitude to the right gives all copies of the fill bit.
- R6: Opcode 5 (exponent detect) sets `exponent` to minus the number of bits directly below operand bit 15 that equal bit 15, so the value lies between 0 and -15. `result` is unchanged.
- R7: For an operand of 0x0000 or 0xFFFF, exponent detect gives -15.
- R8: Opcode 6 loads `amount` into `exponent` and leaves `result` unchanged.
- R9: Opcode 3 (normalize) shifts the placed field by minus `exponent`. The field is arithmetic when `hi_sel`=1 and logical when `hi_sel`=0. `exponent` is unchanged.
- R10: Opcode 4 (denormalize) shifts the placed field by plus `exponent`, so a negative exponent shifts right. The fill rule is the same as for opcode 3.
- R11: When `merge`=1 during opcodes 1 to 4, `result` becomes the bitwise OR of its old value and the new shifted value.
- R12: Opcode 0 and the unused opcode 7 leave both `result` and `exponent` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| hi_sel | input | 1 | 1 places the operand in the upper half, 0 in the lower half |
| merge | input | 1 | OR the new shift result into the existing result |
| operand | input | 16 | Data operand |
| amount | input | 8 | Signed shift amount, or the value for an exponent load |
| result | output | 32 | Registered shift result |
| exponent | output | 8 | Registered signed exponent |

## Verification
Some properties hold on every cycle, and the assertions check those. After reset both registers are zero. The exponent stays within 0 to -15 after a detect. Idle opcodes hold both registers. Shifts leave the exponent alone, and exponent operations leave the result alone. A merge never clears a bit that was already set. A large left shift clears the result.

The exact shifted values need the bench's sweeps to show them. These cover signed amounts from -40 to +40, both placements and both fill modes. They also include a strided sweep of operands through exponent detect and normalize, denormalize runs against loaded exponents, and two-half word assembly through merge.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    localparam int BFS_DW = 16;
    localparam int BFS_AW = 8;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LSH    = 3'd1,
        OP_ASH    = 3'd2,
        OP_NORM   = 3'd3,
        OP_DENORM = 3'd4,
        OP_EXP    = 3'd5,
        OP_SETEXP = 3'd6
    } bfs_op_e;

    // Decoded control for one operation
    typedef struct packed {
        logic shift_en;   // writes result
        logic arith_fix;  // arithmetic field regardless of half
        logic arith_hi;   // arithmetic field only when upper half selected
        logic use_exp;    // amount comes from exponent register
        logic neg_exp;    // negate exponent before use
        logic exp_det;    // exponent register takes detected exponent
        logic exp_load;   // exponent register takes amount input
    } bfs_ctl_t;

    function automatic bfs_ctl_t bfs_decode(logic [2:0] op);
        bfs_ctl_t c;
        c = '0;
        case (op)
            OP_LSH:    c.shift_en = 1'b1;
            OP_ASH:    begin c.shift_en = 1'b1; c.arith_fix = 1'b1; end
            OP_NORM:   begin c.shift_en = 1'b1; c.arith_hi = 1'b1;
                             c.use_exp = 1'b1; c.neg_exp = 1'b1; end
            OP_DENORM: begin c.shift_en = 1'b1; c.arith_hi = 1'b1;
                             c.use_exp = 1'b1; end
            OP_EXP:    c.exp_det = 1'b1;
            OP_SETEXP: c.exp_load = 1'b1;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bfs_place.sv
module bfs_place #(
    parameter int DW = bfs_pkg::BFS_DW,
    localparam int RW = 2 * DW
) (
    input  logic [DW-1:0] operand,
    input  logic          hi_sel,
    input  logic          arith,
    output logic [RW-1:0] placed,
    output logic          fill
);
    always_comb begin
        if (hi_sel)
            placed = {operand, {DW{1'b0}}};
        else if (arith)
            placed = {{DW{operand[DW-1]}}, operand};
        else
            placed = {{DW{1'b0}}, operand};
        fill = arith & placed[RW-1];
    end
endmodule

// File: rtl/bfs_shift.sv
module bfs_shift #(
    parameter int RW = 32,
    parameter int SW = 9,
    localparam int LW = $clog2(RW)
) (
    input  logic [RW-1:0] din,
    input  logic          fill,
    input  logic [SW-1:0] amt,
    output logic [RW-1:0] dout
);
    logic          neg;
    logic [SW-1:0] mag;
    logic          over;
    logic [RW-1:0] stg [0:LW];

    assign neg  = amt[SW-1];
    assign mag  = neg ? (~amt + 1'b1) : amt;
    assign over = (mag >= SW'(RW));
    assign stg[0] = din;

    // One stage per bit of the magnitude, direction chosen per stage
    for (genvar k = 0; k < LW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [RW-1:0] lft, rgt;
        assign lft = {stg[k][RW-1-S:0], {S{1'b0}}};
        assign rgt = {{S{fill}}, stg[k][RW-1:S]};
        assign stg[k+1] = mag[k] ? (neg ? rgt : lft) : stg[k];
    end

    always_comb begin
        if (over)
            dout = neg ? {RW{fill}} : '0;
        else
            dout = stg[LW];
    end
endmodule

// File: rtl/bfs_expdet.sv
module bfs_expdet #(
    parameter int DW = bfs_pkg::BFS_DW,
    parameter int AW = bfs_pkg::BFS_AW,
    localparam int CW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    output logic [AW-1:0] expo
);
    logic [CW-1:0] cnt;
    logic          run;

    always_comb begin
        cnt = '0;
        run = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && (din[i] == din[DW-1]))
                cnt = cnt + 1'b1;
            else
                run = 1'b0;
        end
        expo = '0 - AW'(cnt);
    end
endmodule

// File: rtl/bfs_unit.sv
module bfs_unit #(
    parameter int DW = bfs_pkg::BFS_DW,
    parameter int AW = bfs_pkg::BFS_AW,
    localparam int RW = 2 * DW,
    localparam int SW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op,
    input  logic          hi_sel,
    input  logic          merge,
    input  logic [DW-1:0] operand,
    input  logic [AW-1:0] amount,
    output logic [RW-1:0] result,
    output logic [AW-1:0] exponent
);
    import bfs_pkg::*;

    bfs_ctl_t      ctl;
    logic          arith;
    logic [SW-1:0] exp_ext, amt_ext, eff_amt;
    logic [RW-1:0] placed, shifted;
    logic          fill;
    logic [AW-1:0] det_exp;
    logic [RW-1:0] res_q;
    logic [AW-1:0] exp_q;

    assign ctl     = bfs_decode(op);
    assign arith   = ctl.arith_fix | (ctl.arith_hi & hi_sel);
    assign exp_ext = {exp_q[AW-1], exp_q};
    assign amt_ext = {amount[AW-1], amount};

    always_comb begin
        if (ctl.use_exp)
            eff_amt = ctl.neg_exp ? ('0 - exp_ext) : exp_ext;
        else
            eff_amt = amt_ext;
    end

    bfs_place #(.DW(DW)) u_place (
        .operand (operand),
        .hi_sel  (hi_sel),
        .arith   (arith),
        .placed  (placed),
        .fill    (fill)
    );

    bfs_shift #(.RW(RW), .SW(SW)) u_shift (
        .din  (placed),
        .fill (fill),
        .amt  (eff_amt),
        .dout (shifted)
    );

    bfs_expdet #(.DW(DW), .AW(AW)) u_expdet (
        .din  (operand),
        .expo (det_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            exp_q <= '0;
        end else begin
            if (ctl.shift_en)
                res_q <= merge ? (res_q | shifted) : shifted;
            if (ctl.exp_det)
                exp_q <= det_exp;
            else if (ctl.exp_load)
                exp_q <= amount;
        end
    end

    assign result   = res_q;
    assign exponent = exp_q;
endmodule

// File: rtl/bfs_unit_chk.sv
module bfs_unit_chk #(
    parameter int DW = bfs_pkg::BFS_DW,
    parameter int AW = bfs_pkg::BFS_AW,
    localparam int RW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    op,
    input logic          hi_sel,
    input logic          merge,
    input logic [DW-1:0] operand,
    input logic [AW-1:0] amount,
    input logic [RW-1:0] result,
    input logic [AW-1:0] exponent
);
    import bfs_pkg::*;

    logic is_shift;
    assign is_shift = (op == OP_LSH) || (op == OP_ASH) ||
                      (op == OP_NORM) || (op == OP_DENORM);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (result == '0 && exponent == '0)); // R1

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_EXP) |=> ($signed(exponent) <= 0 && $signed(exponent) >= -15)); // R6

    AST_EXP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_EXP || op == OP_SETEXP) |=> $stable(result)); // R8

    AST_SHIFT_KEEPS_EXP: assert property (@(posedge clk) disable iff (rst)
        is_shift |=> $stable(exponent)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NOP || op == 3'd7) |=> ($stable(result) && $stable(exponent))); // R12

    AST_MERGE_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (is_shift && merge) |=> ((result & $past(result)) == $past(result))); // R11

    AST_BIG_LEFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LSH && !merge && $signed(amount) >= 32) |=> (result == '0)); // R5

    initial assert (DW >= 2 && AW >= 2); // R2
endmodule

bind bfs_unit bfs_unit_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .op(op), .hi_sel(hi_sel), .merge(merge),
    .operand(operand), .amount(amount), .result(result), .exponent(exponent)
);

// File: tb/bfs_unit_test.sv
`timescale 1ns/1ps
module bfs_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op;
    logic        hi_sel;
    logic        merge;
    logic [15:0] operand;
    logic [7:0]  amount;
    logic [31:0] result;
    logic [7:0]  exponent;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl_res;
    int          mdl_exp;

    always #2 clk = ~clk;

    bfs_unit uut (
        .clk(clk), .rst(rst), .op(op), .hi_sel(hi_sel), .merge(merge),
        .operand(operand), .amount(amount), .result(result), .exponent(exponent)
    );

    function automatic logic [31:0] m_place(logic [15:0] v, bit hi, bit ar);
        if (hi) return {v, 16'h0000};
        return ar ? 32'($signed(v)) : 32'(v);
    endfunction

    function automatic logic [31:0] m_shift(logic [31:0] p, bit ar, int a);
        int n;
        if (a >= 0) return (a >= 32) ? 32'h0 : (p << a);
        n = -a;
        if (n >= 32) return (ar && p[31]) ? 32'hFFFF_FFFF : 32'h0;
        return ar ? 32'($signed(p) >>> n) : (p >> n);
    endfunction

    function automatic int m_exp(logic [15:0] v);
        int s, n;
        s = int'($signed(v));
        n = 0;
        while (n < 15 && (s * (2 ** (n + 1))) <= 32767 && (s * (2 ** (n + 1))) >= -32768)
            n++;
        return -n;
    endfunction

    task automatic check(string tag);
        checks++;
        if (result !== mdl_res || int'($signed(exponent)) != mdl_exp) begin
            errors++;
            $display("FAIL %s result=%h exponent=%0d expected result=%h exponent=%0d",
                     tag, result, $signed(exponent), mdl_res, mdl_exp);
        end
    endtask

    task automatic run(logic [2:0] o, bit h, bit m, logic [15:0] v, int a, string tag);
        logic [31:0] nv;
        @(negedge clk);
        op = o; hi_sel = h; merge = m; operand = v; amount = a[7:0];
        @(posedge clk);
        #1;
        nv = mdl_res;
        case (o)
            3'd1: nv = m_shift(m_place(v, h, 0), 0, int'($signed(a[7:0])));
            3'd2: nv = m_shift(m_place(v, h, 1), 1, int'($signed(a[7:0])));
            3'd3: nv = m_shift(m_place(v, h, h), h, -mdl_exp);
            3'd4: nv = m_shift(m_place(v, h, h), h, mdl_exp);
            3'd5: mdl_exp = m_exp(v);
            3'd6: mdl_exp = int'($signed(a[7:0]));
            default: ;
        endcase
        if (o >= 3'd1 && o <= 3'd4) mdl_res = m ? (mdl_res | nv) : nv;
        check(tag);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog result=%h exponent=%0d expected finish", result, $signed(exponent));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pats [6];
        pats = '{16'h8001, 16'h7FFF, 16'h1234, 16'hC3A5, 16'h0001, 16'hFFFF};
        op = 3'd0; hi_sel = 0; merge = 0; operand = 16'h0; amount = 8'h0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        mdl_res = 32'h0; mdl_exp = 0;
        check("R1 reset state");
        @(negedge clk); rst = 1'b0;

        // R2 R3 R4 R5: shift sweeps over amounts, placements and fill modes
        foreach (pats[p]) begin
            for (int a = -40; a <= 40; a++) begin
                for (int h = 0; h < 2; h++) begin
                    if (a >= 32 || a <= -32) begin
                        run(3'd1, h[0], 0, pats[p], a, "R5 logical out-of-range");
                        run(3'd2, h[0], 0, pats[p], a, "R5 arithmetic out-of-range");
                    end else begin
                        run(3'd1, h[0], 0, pats[p], a, "R3 R2 logical shift");
                        run(3'd2, h[0], 0, pats[p], a, "R4 R2 arithmetic shift");
                    end
                end
            end
        end

        // R7 saturation corners
        run(3'd5, 0, 0, 16'h0000, 0, "R7 zero operand");
        run(3'd5, 0, 0, 16'hFFFF, 0, "R7 all-ones operand");
        run(3'd5, 0, 0, 16'h8000, 0, "R6 min operand");
        run(3'd5, 0, 0, 16'h4000, 0, "R6 no redundant sign");

        // R6 R9: strided operand sweep through detect then normalize
        for (int v = 0; v < 65536; v += 7) begin
            run(3'd5, 0, 0, 16'(v), 0, "R6 exponent detect");
            run(3'd3, v[0], 0, 16'(v), 0, "R9 normalize");
        end

        // R8 R10: loaded exponents then denormalize
        foreach (pats[p]) begin
            for (int e = -40; e <= 40; e += 3) begin
                run(3'd6, 0, 0, 16'h0, e, "R8 exponent load");
                run(3'd4, 1, 0, pats[p], 0, "R10 denormalize upper");
                run(3'd4, 0, 0, pats[p], 0, "R10 denormalize lower");
            end
        end

        // R11: two-half assembly through merge
        run(3'd1, 1, 0, 16'hA5C3, 0, "R11 upper half");
        run(3'd1, 0, 1, 16'h3C5A, 0, "R11 merged lower half");
        run(3'd2, 0, 1, 16'h0F00, -4, "R11 merged arithmetic");
        run(3'd1, 0, 1, 16'hFFFF, 8, "R11 merged shifted");

        // R12: idle opcodes hold state
        run(3'd6, 0, 0, 16'h0, -5, "R8 exponent load before idle");
        run(3'd0, 1, 1, 16'hFFFF, 3, "R12 nop holds");
        run(3'd7, 0, 1, 16'h1234, -3, "R12 unused opcode holds");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule